// File: doc/BRIEF.md
# System Clock Mode Controller

This block picks the source of the internal system clock and the rate at which it runs. It has two oscillator sources: a fast main oscillator and a slow sub oscillator. The sources enter as one-cycle tick pulses that are already synchronous to the block clock. Software sets the operating mode by writing a 4-bit mode word. The bits are a sub-oscillator enable, a main-oscillator stop, a main divide select (divide by 2 for fast operation, divide by 8 for medium operation) and a source select (main or sub). The block puts out a one-cycle system clock enable at the selected rate. It also drives the two oscillator enables and shows the current mode word.

Only one-step mode changes are accepted, and they must follow a fixed graph. A write may change at most one bit. Some changes also depend on the other bits: the sub oscillator must run before it can become the source, and the main oscillator may stop only while the sub oscillator is the source. After the main oscillator restarts, a settle counter must finish before the source can move back to main. A write that breaks a rule is dropped and raises an error flag for one cycle.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After synchronous reset, mode_q is 4'b0100 (medium rate on main). main_osc_en is 1, sub_osc_en is 0, main_ready is 1 and illegal_wr is 0.
- R2: Mode bit 0 is the sub enable and drives sub_osc_en. Mode bit 1 is the main stop, and main_osc_en is its inverse. Bit 2 is the divide select (0 is divide by 2, 1 is divide by 8). Bit 3 is the source (0 is main, 1 is sub).
- R3: A write that differs from mode_q in more than one bit is dropped: mode_q is unchanged and illegal_wr is 1 for the one cycle after the write.
- R4: Setting bit 3 is accepted only while bit 0 is 1.
- R5: Setting bit 1 is accepted only while bit 3 is 1. Clearing bit 0 is accepted only while bit 3 is 0.
- R6: Clearing bit 3 is accepted only while bit 1 is 0 and main_ready is 1.
- R7: Bit 2 may be toggled in every mode.
- R8: main_ready is 0 while the main oscillator is stopped. After bit 1 is cleared, main_ready returns to 1 once STAB_TICKS main ticks have been counted.
- R9: With bit 3 = 0, sys_ce pulses once per 2 main ticks when bit 2 = 0, and once per 8 main ticks when bit 2 = 1.
- R10: With bit 3 = 1, sys_ce pulses once per 2 sub ticks, whatever the value of bit 2.
- R11: Ticks from a stopped or disabled oscillator produce no sys_ce and do not advance any counter.
- R12: A legal write updates mode_q on the next clock with illegal_wr at 0. Writing the current value is legal and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode write strobe |
| wr_data | input | 4 | Requested mode word |
| main_tick | input | 1 | One pulse per main oscillator cycle |
| sub_tick | input | 1 | One pulse per sub oscillator cycle |
| sys_ce | output | 1 | System clock enable pulse |
| main_osc_en | output | 1 | Main oscillator run enable |
| sub_osc_en | output | 1 | Sub oscillator run enable |
| mode_q | output | 4 | Current mode word |
| main_ready | output | 1 | Main oscillator settled |
| illegal_wr | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench writes jumps of two bits, sets the source before the sub oscillator runs, and stops the main oscillator while it is still the source. A design that checked only the target mode, or counted only how many bits changed, would accept these writes and could leave the chip without a running clock. The bench also tries to return to main right after a restart, while the settle count is still running. An early main_ready would let this switch through on an unsettled clock. Ticks are fed from oscillators that are stopped or disabled, and the divide select is toggled in sub mode. A wrong gate or a wrong rate mux would then show up as stray or missing sys_ce pulses against the cycle-level reference.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    typedef struct packed {
        logic src_sel;    // bit 3: 0 main, 1 sub
        logic div_sel;    // bit 2: 0 divide by 2, 1 divide by 8
        logic main_stop;  // bit 1: 1 stops main oscillator
        logic sub_en;     // bit 0: 1 runs sub oscillator
    } mode_t;

    localparam mode_t MODE_RESET = '{src_sel: 1'b0, div_sel: 1'b1, main_stop: 1'b0, sub_en: 1'b0};

    typedef enum logic [1:0] {SRC_MAIN = 2'd0, SRC_SUB = 2'd1} src_idx_e;

    function automatic logic step_ok(mode_t cur, mode_t nxt, logic ready);
        mode_t diff;
        logic  ok;
        diff = cur ^ nxt;
        ok   = 1'b0;
        if (diff == '0) begin
            ok = 1'b1;
        end else if ($onehot(diff)) begin
            if (diff.sub_en)
                ok = nxt.sub_en | ~cur.src_sel;
            else if (diff.main_stop)
                ok = ~nxt.main_stop | cur.src_sel;
            else if (diff.div_sel)
                ok = 1'b1;
            else
                ok = nxt.src_sel ? cur.sub_en : (~cur.main_stop & ready);
        end
        return ok;
    endfunction

endpackage

// File: rtl/clk_mode_reg.sv
module clk_mode_reg
    import sysclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_data,
    input  logic  main_ready,
    output mode_t mode_q,
    output logic  illegal_q
);
    logic accept;

    always_comb accept = step_ok(mode_q, wr_data, main_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_RESET;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= wr_en & ~accept;
            if (wr_en && accept)
                mode_q <= wr_data;
        end
    end
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
    parameter int STAB_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic ready
);
    localparam int SW = $clog2(STAB_TICKS + 1);
    localparam logic [SW-1:0] FULL = SW'(STAB_TICKS);

    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= FULL;
        else if (!run)
            cnt <= '0;
        else if (tick && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    always_comb ready = run & (cnt == FULL);
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;
    logic             at_lim;

    always_comb begin
        at_lim = (cnt >= limit);
        wrap   = tick & at_lim;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= at_lim ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
    import sysclk_pkg::*;
#(
    parameter int MAIN_DIV_FAST = 2,
    parameter int MAIN_DIV_SLOW = 8,
    parameter int SUB_DIV       = 2,
    parameter int STAB_TICKS    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    input  logic       main_tick,
    input  logic       sub_tick,
    output logic       sys_ce,
    output logic       main_osc_en,
    output logic       sub_osc_en,
    output logic [3:0] mode_q,
    output logic       main_ready,
    output logic       illegal_wr
);
    localparam int DIV_MAX = (MAIN_DIV_SLOW > MAIN_DIV_FAST)
                           ? ((MAIN_DIV_SLOW > SUB_DIV) ? MAIN_DIV_SLOW : SUB_DIV)
                           : ((MAIN_DIV_FAST > SUB_DIV) ? MAIN_DIV_FAST : SUB_DIV);
    localparam int CNT_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(MAIN_DIV_FAST - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(MAIN_DIV_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_SUB  = CNT_W'(SUB_DIV - 1);
    localparam int NSRC = 2;

    mode_t            mode;
    logic             ready;
    logic [NSRC-1:0]  src_tick;
    logic [NSRC-1:0]  src_wrap;
    logic [CNT_W-1:0] src_lim [NSRC];

    clk_mode_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (mode_t'(wr_data)),
        .main_ready (ready),
        .mode_q     (mode),
        .illegal_q  (illegal_wr)
    );

    osc_settle_timer #(.STAB_TICKS(STAB_TICKS)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .run   (~mode.main_stop),
        .tick  (main_tick),
        .ready (ready)
    );

    always_comb begin
        src_tick[SRC_MAIN] = main_tick & ~mode.main_stop;
        src_tick[SRC_SUB]  = sub_tick & mode.sub_en;
        src_lim[SRC_MAIN]  = mode.div_sel ? LIM_SLOW : LIM_FAST;
        src_lim[SRC_SUB]   = LIM_SUB;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_div
        tick_divider #(.CNT_W(CNT_W)) u_div (
            .clk   (clk),
            .rst   (rst),
            .tick  (src_tick[g]),
            .limit (src_lim[g]),
            .wrap  (src_wrap[g])
        );
    end

    always_comb begin
        sys_ce      = mode.src_sel ? src_wrap[SRC_SUB] : src_wrap[SRC_MAIN];
        main_osc_en = ~mode.main_stop;
        sub_osc_en  = mode.sub_en;
        mode_q      = mode;
        main_ready  = ready;
    end
endmodule

// File: rtl/sysclk_mode_chk.sv
module sysclk_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       main_tick,
    input logic       sub_tick,
    input logic       sys_ce,
    input logic       main_osc_en,
    input logic       sub_osc_en,
    input logic [3:0] mode_q,
    input logic       main_ready,
    input logic       illegal_wr
);
    // R3
    rejected_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_wr |-> mode_q == $past(mode_q));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(mode_q ^ $past(mode_q)) <= 1);

    // R4
    src_needs_sub_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q[3] |-> sub_osc_en);

    // R5
    stop_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        !main_osc_en |-> mode_q[3]);

    // R6
    return_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_q[3]) |-> $past(main_ready));

    // R8
    stopped_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !main_osc_en |-> !main_ready);

    // R11
    ce_needs_live_tick_chk: assert property (@(posedge clk) disable iff (rst)
        sys_ce |-> ((main_tick && main_osc_en) || (sub_tick && sub_osc_en)));
endmodule

bind sysclk_mode_ctrl sysclk_mode_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .main_tick   (main_tick),
    .sub_tick    (sub_tick),
    .sys_ce      (sys_ce),
    .main_osc_en (main_osc_en),
    .sub_osc_en  (sub_osc_en),
    .mode_q      (mode_q),
    .main_ready  (main_ready),
    .illegal_wr  (illegal_wr)
);

// File: tb/sysclk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl_bench;
    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       main_tick = 1'b0;
    logic       sub_tick = 1'b0;
    logic       sys_ce, main_osc_en, sub_osc_en, main_ready, illegal_wr;
    logic [3:0] mode_q;

    int total = 0;
    int bad = 0;
    int ce_cnt = 0;
    bit finished = 1'b0;

    // reference state
    int m_mode = 4;
    int m_mcnt = 0;
    int m_scnt = 0;
    int m_stab = STAB;
    int m_ill  = 0;

    always #4 clk = ~clk;

    sysclk_mode_ctrl #(.STAB_TICKS(STAB)) u_sysclk_mode_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .main_tick(main_tick), .sub_tick(sub_tick), .sys_ce(sys_ce),
        .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .mode_q(mode_q),
        .main_ready(main_ready), .illegal_wr(illegal_wr)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit ref_ready();
        return ((m_mode & 2) == 0) && (m_stab == STAB);
    endfunction

    function automatic bit ref_legal(int cur, int nxt);
        int d;
        int n;
        d = cur ^ nxt;
        n = 0;
        for (int b = 0; b < 4; b++) if (d[b]) n++;
        if (n == 0) return 1'b1;
        if (n > 1) return 1'b0;
        case (d)
            1: return nxt[0] || !cur[3];
            2: return !nxt[1] || cur[3];
            4: return 1'b1;
            default: return nxt[3] ? bit'(cur[0]) : (!cur[1] && ref_ready());
        endcase
    endfunction

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_mode = 4; m_mcnt = 0; m_scnt = 0; m_stab = STAB; m_ill = 0;
        end else begin
            int lim;
            bit ok;
            ok  = ref_legal(m_mode, int'(wr_data));
            lim = m_mode[2] ? 7 : 1;
            if (main_tick && !m_mode[1]) m_mcnt = (m_mcnt >= lim) ? 0 : m_mcnt + 1;
            if (sub_tick && m_mode[0])   m_scnt = (m_scnt >= 1) ? 0 : m_scnt + 1;
            if (m_mode[1]) m_stab = 0;
            else if (main_tick && m_stab < STAB) m_stab++;
            m_ill = (wr_en && !ok) ? 1 : 0;
            if (wr_en && ok) m_mode = int'(wr_data);
        end
    end

    // compare on every clock, mid-period
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int exp_ce;
            int lim;
            lim = m_mode[2] ? 7 : 1;
            exp_ce = m_mode[3] ? int'(sub_tick && m_mode[0] && m_scnt >= 1)
                               : int'(main_tick && !m_mode[1] && m_mcnt >= lim);
            check("R12 mode_q", int'(mode_q), m_mode);
            check("R3 illegal_wr", int'(illegal_wr), m_ill);
            check("R8 main_ready", int'(main_ready), int'(ref_ready()));
            check("R9/R10 sys_ce", int'(sys_ce), exp_ce);
            check("R2 osc enables", int'({main_osc_en, sub_osc_en}),
                  int'({!m_mode[1], bit'(m_mode[0])}));
            if (sys_ce) ce_cnt++;
        end
    end

    task automatic do_write(input logic [3:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n, input bit m, input bit s);
        ce_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            main_tick = m; sub_tick = s;
        end
        @(posedge clk); #2;
        main_tick = 1'b0; sub_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 mode", int'(mode_q), 4);
        check("R1 enables", int'({main_osc_en, sub_osc_en, main_ready, illegal_wr}), 4'b1010);

        run_ticks(16, 1, 0);
        check("R9 divide by 8", ce_cnt, 2);

        do_write(4'b0000);
        check("R7 div toggle", int'(mode_q), 0);
        run_ticks(10, 1, 0);
        check("R9 divide by 2", ce_cnt, 5);

        do_write(4'b1000);
        check("R4 src without sub", int'({mode_q, illegal_wr}), 5'b00001);
        do_write(4'b0011);
        check("R3 two-bit write", int'({mode_q, illegal_wr}), 5'b00001);
        do_write(4'b0010);
        check("R5 stop on main", int'({mode_q, illegal_wr}), 5'b00001);

        do_write(4'b0001);
        check("R2 sub enable", int'(sub_osc_en), 1);
        do_write(4'b1001);
        check("R4 src with sub", int'({mode_q, illegal_wr}), 5'b10010);
        run_ticks(10, 1, 1);
        check("R10 sub rate", ce_cnt, 5);

        do_write(4'b1101);
        check("R7 div in sub mode", int'(mode_q), 13);
        run_ticks(10, 0, 1);
        check("R10 div ignored", ce_cnt, 5);

        do_write(4'b1100);
        check("R5 sub off while src", int'({mode_q, illegal_wr}), 5'b11011);

        do_write(4'b1111);
        check("R2 main stopped", int'({main_osc_en, main_ready}), 0);
        run_ticks(10, 1, 0);
        check("R11 stopped main ticks", ce_cnt, 0);

        do_write(4'b1101);
        check("R8 not ready on restart", int'(main_ready), 0);
        do_write(4'b0101);
        check("R6 early return", int'({mode_q, illegal_wr}), 5'b11011);
        run_ticks(STAB - 1, 1, 0);
        check("R8 still settling", int'(main_ready), 0);
        run_ticks(1, 1, 0);
        check("R8 settled", int'(main_ready), 1);

        do_write(4'b0101);
        check("R6 return to main", int'({mode_q, illegal_wr}), 5'b01010);
        do_write(4'b0101);
        check("R12 same value", int'({mode_q, illegal_wr}), 5'b01010);
        do_write(4'b0100);
        check("R12 sub off", int'({mode_q, sub_osc_en}), 5'b01000);
        run_ticks(10, 0, 1);
        check("R11 disabled sub ticks", ce_cnt, 0);

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        finished = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule